// File: doc/BRIEF.md
# Buffered Field Transfer Engine with Record Linking

This block carries out buffer-based transfers for a single channel. A channel record made of two 32-bit control words drives it: an active word that holds the supervision code, the operation code, a 10-bit boundary tag and a 16-bit word address counter, and a standby word laid out the same way. Each word that the device offers or asks for becomes one 16-bit memory access at the address the counter holds. After every word except the last word of the buffer, the counter steps forward by one.

On the last word, a plain operation retires: its opcode becomes 0000 and a one-cycle completion event fires. A linking operation instead swaps the whole active word with the standby word in that same cycle and fires a one-cycle link event. The next device word then runs against the swapped-in buffer, so chained buffers continue without a gap. The program writes the record through a load strobe. The record read-back shows a distinct pseudo opcode while a load-with-link is held under program control.

Top module: `field_xfer_engine`

## Requirements
- R1: After reset, mem_req, dev_ack, done_evt and link_evt are 0 and both record read-back words are all zero.
- R2: With opcode 0111 (store), each device word is written to memory at the address in the counter field (bits 15:0 of the active word). The counter increases by one after every word that is not the last of the buffer.
- R3: With opcode 1111 (load), each transfer reads memory at the counter address and returns the word on dev_rdata in the cycle dev_ack is high.
- R4: A memory request keeps mem_req, mem_addr, mem_we and mem_wdata unchanged until mem_ack. Only one access is outstanding at a time. dev_ack rises in the cycle after the one where mem_ack is seen, so a device word completes 2 + N cycles after dev_req when memory waits N cycles.
- R5: For the load codes (1111, 1011), the last word is the one whose counter bits 9:0 equal the tag field (bits 25:16). That word is transferred and the counter is left unchanged.
- R6: For the store codes (0111, 0011), the last word is the one whose counter bits 9:0 equal (tag + BUF_LEN - 1) mod 1024, wrap-around included. The counter is left unchanged on that word.
- R7: When a non-linking operation reaches its last word, the opcode field (bits 29:26) becomes 0000 and done_evt pulses for one cycle together with dev_ack. Later device requests cause no memory access.
- R8: When a linking operation (0011 or 1011) reaches its last word, the active and standby words are exchanged in full in the cycle dev_ack is high. link_evt pulses for that cycle and done_evt stays low.
- R9: After an exchange, the next device word uses the swapped-in opcode and counter.
- R10: With supervision code 01 (bits 31:30), no transfer starts. If the stored opcode is 1011, the active word read-back shows opcode 1010.
- R11: A record load (cfg_load) that arrives while a memory access is outstanding is ignored.
- R12: Opcodes other than 0111, 1111, 0011 and 1011 start no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Write both record words (taken only when no access is outstanding) |
| cfg_w0 | input | 32 | Active record word to write |
| cfg_w2 | input | 32 | Standby record word to write |
| rec_w0 | output | 32 | Active record word read-back (shows pseudo opcode 1010 when held) |
| rec_w2 | output | 32 | Standby record word read-back |
| dev_req | input | 1 | Device offers (store) or asks for (load) one word |
| dev_wdata | input | DATA_W | Device word to store |
| dev_ack | output | 1 | One-cycle completion of a device word |
| dev_rdata | output | DATA_W | Loaded word, valid with dev_ack |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory access accepted |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| done_evt | output | 1 | Pulse: non-linking operation finished its buffer |
| link_evt | output | 1 | Pulse: record words exchanged at a buffer boundary |

## Verification
The assertions check the following on every cycle:
- the memory request stays stable until it is acknowledged, and dev_ack follows an acknowledged access;
- done_evt and link_evt only pulse together with dev_ack and never both at once, and done_evt comes with an opcode of 0000;
- each link event leaves the old active word in the standby slot;
- an access starts only from a field opcode with the program not in control;
- the record stays frozen while an access is outstanding.

Only the bench scenarios can show the rest: the counter addressing and data, the exact word on which each boundary falls (including the tag wrap-around for stores), the continuation into the swapped buffer, the pseudo opcode in the read-back, and the total counts of completion and link events.

// File: rtl/fxe_pkg.sv
package fxe_pkg;
    localparam int SUP_W  = 2;
    localparam int OP_W   = 4;
    localparam int TAG_W  = 10;
    localparam int CTR_W  = 16;
    localparam int OPND_W = TAG_W + CTR_W;
    localparam int REC_W  = SUP_W + OP_W + OPND_W;

    localparam logic [OP_W-1:0]  OP_IDLE          = 4'b0000;
    localparam logic [OP_W-1:0]  OP_STORE         = 4'b0111;
    localparam logic [OP_W-1:0]  OP_LOAD          = 4'b1111;
    localparam logic [OP_W-1:0]  OP_STORE_LNK     = 4'b0011;
    localparam logic [OP_W-1:0]  OP_LOAD_LNK      = 4'b1011;
    localparam logic [OP_W-1:0]  OP_LOAD_LNK_HELD = 4'b1010;
    localparam logic [SUP_W-1:0] SUP_PROGRAM      = 2'b01;

    // Record word, most significant field first
    typedef struct packed {
        logic [SUP_W-1:0] sup;
        logic [OP_W-1:0]  op;
        logic [TAG_W-1:0] tag;
        logic [CTR_W-1:0] ctr;
    } rec_t;

    typedef enum logic { PH_IDLE, PH_MEM } phase_e;

    function automatic logic op_is_store(input logic [OP_W-1:0] op);
        return (op == OP_STORE) || (op == OP_STORE_LNK);
    endfunction

    function automatic logic op_is_load(input logic [OP_W-1:0] op);
        return (op == OP_LOAD) || (op == OP_LOAD_LNK);
    endfunction

    function automatic logic op_is_link(input logic [OP_W-1:0] op);
        return (op == OP_STORE_LNK) || (op == OP_LOAD_LNK);
    endfunction
endpackage

// File: rtl/fxe_boundary.sv
module fxe_boundary
    import fxe_pkg::*;
#(
    parameter int BUF_LEN = 8
) (
    input  rec_t cur,
    output logic runnable,
    output logic is_store,
    output logic is_link,
    output logic last_word
);
    localparam int SPAN_I = (BUF_LEN - 1) % (1 << TAG_W);
    localparam logic [TAG_W-1:0] SPAN = TAG_W'(SPAN_I);

    logic [TAG_W-1:0] store_last;
    logic [TAG_W-1:0] ctr_low;

    generate
        if (SPAN_I == 0) begin : g_single
            assign store_last = cur.tag;
        end else begin : g_span
            assign store_last = cur.tag + SPAN;
        end
    endgenerate

    always_comb begin
        ctr_low   = cur.ctr[TAG_W-1:0];
        is_store  = op_is_store(cur.op);
        is_link   = op_is_link(cur.op);
        runnable  = (is_store || op_is_load(cur.op)) && (cur.sup != SUP_PROGRAM);
        last_word = is_store ? (ctr_low == store_last) : (ctr_low == cur.tag);
    end
endmodule

// File: rtl/fxe_record.sv
module fxe_record
    import fxe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  rec_t load_w0,
    input  rec_t load_w2,
    input  logic advance,
    input  logic exchange,
    input  logic retire,
    output rec_t w0,
    output rec_t w2
);
    typedef struct packed {
        rec_t act;
        rec_t stby;
    } pair_t;

    pair_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.act  = load_w0;
            st_d.stby = load_w2;
        end else if (exchange) begin
            st_d.act  = st_q.stby;
            st_d.stby = st_q.act;
        end else if (retire) begin
            st_d.act.op = OP_IDLE;
        end else if (advance) begin
            st_d.act.ctr = st_q.act.ctr + CTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign w0 = st_q.act;
    assign w2 = st_q.stby;
endmodule

// File: rtl/field_xfer_engine.sv
module field_xfer_engine
    import fxe_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int BUF_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [31:0]       cfg_w0,
    input  logic [31:0]       cfg_w2,
    output logic [31:0]       rec_w0,
    output logic [31:0]       rec_w2,
    input  logic              dev_req,
    input  logic [DATA_W-1:0] dev_wdata,
    output logic              dev_ack,
    output logic [DATA_W-1:0] dev_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [15:0]       mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done_evt,
    output logic              link_evt
);
    typedef struct packed {
        phase_e            ph;
        logic              mreq;
        logic              mwe;
        logic [CTR_W-1:0]  maddr;
        logic [DATA_W-1:0] mwdata;
        logic              dack;
        logic [DATA_W-1:0] drdata;
        logic              done;
        logic              link;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    rec_t w0, w2, w0_view;
    logic runnable, is_store, is_link, last_word;
    logic rec_load, adv, xchg, ret;

    fxe_record u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (rec_load),
        .load_w0  (rec_t'(cfg_w0)),
        .load_w2  (rec_t'(cfg_w2)),
        .advance  (adv),
        .exchange (xchg),
        .retire   (ret),
        .w0       (w0),
        .w2       (w2)
    );

    fxe_boundary #(.BUF_LEN(BUF_LEN)) u_bnd (
        .cur       (w0),
        .runnable  (runnable),
        .is_store  (is_store),
        .is_link   (is_link),
        .last_word (last_word)
    );

    // Record writes only land while no access is in flight
    assign rec_load = cfg_load && (ctl_q.ph == PH_IDLE);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.dack = 1'b0;
        ctl_d.done = 1'b0;
        ctl_d.link = 1'b0;
        adv        = 1'b0;
        xchg       = 1'b0;
        ret        = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (dev_req && runnable && !cfg_load) begin
                    ctl_d.ph     = PH_MEM;
                    ctl_d.mreq   = 1'b1;
                    ctl_d.mwe    = is_store;
                    ctl_d.maddr  = w0.ctr;
                    ctl_d.mwdata = dev_wdata;
                end
            end
            PH_MEM: begin
                if (mem_ack) begin
                    ctl_d.ph     = PH_IDLE;
                    ctl_d.mreq   = 1'b0;
                    ctl_d.dack   = 1'b1;
                    ctl_d.drdata = is_store ? '0 : mem_rdata;
                    if (!last_word) begin
                        adv = 1'b1;
                    end else if (is_link) begin
                        xchg       = 1'b1;
                        ctl_d.link = 1'b1;
                    end else begin
                        ret        = 1'b1;
                        ctl_d.done = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Held load-with-link shows its pseudo code in the read-back
    always_comb begin
        w0_view = w0;
        if (w0.sup == SUP_PROGRAM && w0.op == OP_LOAD_LNK) w0_view.op = OP_LOAD_LNK_HELD;
    end

    assign rec_w0    = w0_view;
    assign rec_w2    = w2;
    assign dev_ack   = ctl_q.dack;
    assign dev_rdata = ctl_q.drdata;
    assign mem_req   = ctl_q.mreq;
    assign mem_we    = ctl_q.mwe;
    assign mem_addr  = ctl_q.maddr;
    assign mem_wdata = ctl_q.mwdata;
    assign done_evt  = ctl_q.done;
    assign link_evt  = ctl_q.link;
endmodule

// File: rtl/fxe_checker.sv
module fxe_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dev_req,
    input logic              dev_ack,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [15:0]       mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              done_evt,
    input logic              link_evt,
    input logic [31:0]       rec_w0,
    input logic [31:0]       rec_w2
);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> $past(mem_req && mem_ack));

    assert_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt || link_evt) |-> (dev_ack && $onehot0({done_evt, link_evt})));

    assert_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |-> (rec_w0[29:26] == 4'b0000));

    assert_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_evt |-> (rec_w2 == $past(rec_w0)));

    assert_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> ($past(dev_req) && ($past(rec_w0[31:30]) != 2'b01)));

    assert_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> ($past(rec_w0[27:26]) == 2'b11));

    assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(rec_w0) && $stable(rec_w2)));
endmodule

bind field_xfer_engine fxe_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_req   (dev_req),
    .dev_ack   (dev_ack),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done_evt  (done_evt),
    .link_evt  (link_evt),
    .rec_w0    (rec_w0),
    .rec_w2    (rec_w2)
);

// File: tb/sim_field_xfer_engine.sv
module sim_field_xfer_engine;
    localparam int BL = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [31:0]   cfg_w0 = '0, cfg_w2 = '0;
    logic [31:0]   rec_w0, rec_w2;
    logic          dev_req = 1'b0;
    logic [DW-1:0] dev_wdata = '0;
    logic          dev_ack;
    logic [DW-1:0] dev_rdata;
    logic          mem_req, mem_we;
    logic [15:0]   mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          done_evt, link_evt;

    field_xfer_engine #(.DATA_W(DW), .BUF_LEN(BL)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_w0(cfg_w0), .cfg_w2(cfg_w2),
        .rec_w0(rec_w0), .rec_w2(rec_w2), .dev_req(dev_req), .dev_wdata(dev_wdata),
        .dev_ack(dev_ack), .dev_rdata(dev_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done_evt(done_evt), .link_evt(link_evt)
    );

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [15:0] data;
    } acc_t;

    acc_t        expq[$];
    logic [15:0] mem [0:1023];
    int mem_wait = 0;
    int n_chk = 0, n_fail = 0;
    int done_cnt = 0, link_cnt = 0;
    bit finished = 0;

    function automatic logic [31:0] rec(input logic [1:0] s, input logic [3:0] o,
                                        input logic [9:0] t, input logic [15:0] c);
        return {s, o, t, c};
    endfunction

    task automatic chk_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Memory model and scoreboard monitor
    initial begin
        int   waited;
        acc_t e;
        waited = 0;
        for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 37) ^ 16'h5A00;
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                if (waited < mem_wait) begin
                    waited++;
                end else begin
                    waited    = 0;
                    mem_ack   = 1'b1;
                    mem_rdata = mem[mem_addr[9:0]];
                    if (expq.size() == 0) begin
                        chk_eq("R12", "unexpected memory access", {15'd0, mem_we, mem_addr}, 32'hFFFF_FFFF);
                    end else begin
                        e = expq.pop_front();
                        chk_eq("R2", "access address", mem_addr, e.addr);
                        chk_eq("R2", "access direction", mem_we, e.we);
                        if (e.we) chk_eq("R2", "store data", mem_wdata, e.data);
                    end
                    if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
                end
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (done_evt) done_cnt++;
            if (link_evt) link_cnt++;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        report();
    end

    task automatic load_rec(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cfg_load = 1'b1; cfg_w0 = a; cfg_w2 = b;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Driver: pushes the expected access, then hands one word to the design
    task automatic xfer(input logic st, input logic [15:0] addr, input logic [15:0] wd,
                        output bit dn, output bit lk);
        acc_t        e;
        logic [15:0] exp_rd;
        int          cyc;
        e.we = st; e.addr = addr; e.data = wd;
        expq.push_back(e);
        exp_rd = st ? 16'h0 : mem[addr[9:0]];
        @(negedge clk);
        dev_req = 1'b1; dev_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!dev_ack && cyc < 60);
        chk_eq("R4", "device completion latency", cyc, 2 + mem_wait);
        if (!st) chk_eq("R3", "loaded word", dev_rdata, exp_rd);
        dn = done_evt; lk = link_evt;
        dev_req = 1'b0;
    endtask

    task automatic idle_probe(input int n, input string req);
        int hits;
        hits = 0;
        @(negedge clk);
        dev_req = 1'b1;
        repeat (n) begin
            @(negedge clk);
            if (dev_ack || mem_req) hits++;
        end
        dev_req = 1'b0;
        chk_eq(req, "activity while not runnable", hits, 0);
    endtask

    initial begin
        bit dn, lk;
        logic [31:0] a, b;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk_eq("R1", "mem_req", mem_req, 0);
        chk_eq("R1", "dev_ack", dev_ack, 0);
        chk_eq("R1", "events", {done_evt, link_evt}, 0);
        chk_eq("R1", "active word", rec_w0, 0);
        chk_eq("R1", "standby word", rec_w2, 0);
        rst_n = 1'b1;

        // R2/R6/R7: plain store of one buffer, memory wait 1
        mem_wait = 1;
        load_rec(rec(2'b10, 4'b0111, 10'h010, 16'h4010), 32'h0);
        for (int i = 0; i < BL; i++) begin
            xfer(1'b1, 16'(16'h4010 + i), 16'(16'hC000 + i), dn, lk);
            if (i < BL - 1) begin
                chk_eq("R2", "counter advance", rec_w0[15:0], 16'(16'h4011 + i));
                chk_eq("R7", "no early completion", {dn, lk}, 0);
            end else begin
                chk_eq("R7", "completion pulse", {dn, lk}, 2'b10);
                chk_eq("R7", "opcode retired", rec_w0[29:26], 4'b0000);
                chk_eq("R6", "last store counter held", rec_w0[15:0], 16'h4017);
            end
        end
        @(negedge clk);
        chk_eq("R7", "completion pulse width", done_evt, 0);
        idle_probe(8, "R7");

        // R3/R5: plain load, no wait
        mem_wait = 0;
        load_rec(rec(2'b10, 4'b1111, 10'h103, 16'h2100), 32'h0);
        for (int i = 0; i < 4; i++) begin
            xfer(1'b0, 16'(16'h2100 + i), 16'h0, dn, lk);
            if (i < 3) chk_eq("R5", "not last yet", {dn, lk}, 0);
            else begin
                chk_eq("R5", "last load completes", {dn, lk}, 2'b10);
                chk_eq("R5", "last load counter held", rec_w0[15:0], 16'h2103);
            end
        end

        // R6/R8/R9: linked store whose end tag wraps, memory wait 3
        mem_wait = 3;
        a = rec(2'b10, 4'b0011, 10'h3FC, 16'h13FC);
        b = rec(2'b10, 4'b0011, 10'h020, 16'h0820);
        load_rec(a, b);
        for (int i = 0; i < BL; i++) begin
            xfer(1'b1, 16'(16'h13FC + i), 16'(16'h7700 + i), dn, lk);
            if (i < BL - 1) chk_eq("R6", "no boundary before wrap end", {dn, lk}, 0);
        end
        chk_eq("R8", "link pulse only", {dn, lk}, 2'b01);
        chk_eq("R8", "standby swapped in", rec_w0, b);
        chk_eq("R8", "old active parked", rec_w2, {a[31:16], 16'h1403});
        xfer(1'b1, 16'h0820, 16'h1234, dn, lk);
        chk_eq("R9", "continues on new counter", rec_w0[15:0], 16'h0821);

        // R10: held load-with-link, then released
        mem_wait = 0;
        b = rec(2'b10, 4'b1111, 10'h051, 16'h0050);
        load_rec(rec(2'b01, 4'b1011, 10'h205, 16'h3204), b);
        chk_eq("R10", "pseudo opcode shown", rec_w0[29:26], 4'b1010);
        idle_probe(6, "R10");
        load_rec(rec(2'b10, 4'b1011, 10'h205, 16'h3204), b);
        chk_eq("R10", "real opcode shown", rec_w0[29:26], 4'b1011);
        xfer(1'b0, 16'h3204, 16'h0, dn, lk);
        chk_eq("R5", "load before tag", {dn, lk}, 0);
        xfer(1'b0, 16'h3205, 16'h0, dn, lk);
        chk_eq("R8", "load link pulse", {dn, lk}, 2'b01);
        chk_eq("R8", "load link swap", rec_w0, b);
        xfer(1'b0, 16'h0050, 16'h0, dn, lk);
        chk_eq("R9", "swapped load advances", rec_w0[15:0], 16'h0051);
        xfer(1'b0, 16'h0051, 16'h0, dn, lk);
        chk_eq("R9", "swapped plain load completes", {dn, lk}, 2'b10);

        // R11: record write during an outstanding access
        load_rec(rec(2'b10, 4'b0111, 10'h000, 16'h0300), 32'h0);
        mem_wait = 6;
        fork
            xfer(1'b1, 16'h0300, 16'hBEEF, dn, lk);
            begin
                do @(negedge clk); while (!mem_req);
                cfg_load = 1'b1;
                cfg_w0 = rec(2'b10, 4'b1111, 10'h3FF, 16'hFFFF);
                cfg_w2 = 32'hDEAD_BEEF;
                @(negedge clk);
                cfg_load = 1'b0;
            end
        join
        chk_eq("R11", "active word kept", rec_w0, rec(2'b10, 4'b0111, 10'h000, 16'h0301));
        chk_eq("R11", "standby word kept", rec_w2, 32'h0);
        mem_wait = 0;

        // R12: word-mode code starts nothing
        load_rec(rec(2'b10, 4'b0100, 10'h000, 16'h0400), 32'h0);
        idle_probe(6, "R12");

        repeat (4) @(negedge clk);
        chk_eq("R2", "scoreboard drained", expq.size(), 0);
        chk_eq("R7", "completion count", done_cnt, 3);
        chk_eq("R8", "link count", link_cnt, 2);
        report();
    end
endmodule